// File: doc/BRIEF.md
# Per-Warp Store Visibility Fence Tracker

This block sits in a GPU core beside the load/store unit. For every warp it keeps the latest write completion time returned by the L2 with that warp's store acknowledgements. This time is the point in global time after which no L1 cache anywhere can still hold a stale copy of the written block. The L2 never stalls stores to blocks that are still leased, so the issuing core must enforce ordering itself. When a warp executes a memory fence, the tracker raises a blocked flag for that warp. The warp scheduler keeps the warp parked while the flag is high.

A fenced warp is released when two conditions hold together: the global time is strictly later than its recorded completion time, and no store of that warp is still waiting for its acknowledgement. On release the warp's entry returns to zero and a one-cycle release pulse carries the warp id. A flag store placed after a fence therefore cannot issue before the preceding data store is visible to every core. Completion is decided by comparing timestamps, not by counting acknowledgements from sharers.

Top module: `fence_tracker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every blocked flag is 0 and no release pulse is asserted.
- R2: A fence for warp w sets fence_blocked_o[w] at the next clock edge. When the warp is eligible (see R3 and R4) during the following cycle, the next edge clears the flag and drives rel_vld_o=1 for exactly one cycle with rel_warp_o=w.
- R3: Each acknowledgement sets the warp's entry to the larger of its current value and the returned completion time. A fenced warp is not released while global_time is less than or equal to its entry.
- R4: Each warp has a 4-bit outstanding-store counter. A store issue adds one, an acknowledgement subtracts one, and both in the same cycle leave it unchanged. A fenced warp with a nonzero count stays blocked whatever the global time.
- R5: A release clears the warp's entry to zero, so a later fence on that warp ignores completion times acknowledged before the release.
- R6: When an acknowledgement and a fence for the same warp arrive in the same cycle, the acknowledgement's time and its decrement both count in the release decision.
- R7: At most one warp is released per cycle. When several are eligible, the lowest warp id goes first and the others follow on later cycles.
- R8: An acknowledgement or store issue for one warp has no effect on whether another warp is released.
- R9: A fence to a warp that is already blocked has no further effect: the warp produces one release pulse.
- R10: The stimulus must not issue a store to a warp whose counter is 15 without a matching acknowledgement, and must not acknowledge a warp whose counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_issue_vld | input | 1 | A store is issued this cycle |
| st_issue_warp | input | WID_W (3) | Warp id of the issued store |
| st_ack_vld | input | 1 | A store acknowledgement arrives this cycle |
| st_ack_warp | input | WID_W (3) | Warp id of the acknowledged store |
| st_ack_gwct | input | TIME_W (16) | Write completion time carried by the acknowledgement |
| fence_vld | input | 1 | A warp executes a fence this cycle |
| fence_warp | input | WID_W (3) | Warp id of the fence |
| global_time | input | TIME_W (16) | Current global time |
| fence_blocked_o | output | NUM_WARPS (8) | Per-warp fence-blocked flag, bit w for warp w |
| rel_vld_o | output | 1 | One-cycle release pulse |
| rel_warp_o | output | WID_W (3) | Warp id released, valid with rel_vld_o |

## Verification
A fence, acknowledgement or store issue takes effect at the first clock edge after it is presented, so the blocked flag is due one edge after the fence. The release decision uses the registered state and the global_time of the cycle that follows, so the pulse and the falling flag are due one edge later still. The bench drives each stimulus vector on a falling edge and compares the outputs on the next falling edge. A hold or a release therefore lands on exactly one vector, and the expected values are written per vector from these latencies.

// File: rtl/fence_pkg.sv
package fence_pkg;
    parameter int unsigned DEF_WARPS   = 8;
    parameter int unsigned DEF_TIME_W  = 16;
    parameter int unsigned DEF_OUTST_W = 4;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_INC  = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_op_e;

    function automatic cnt_op_e cnt_op(input logic issue, input logic ack);
        if (issue && !ack) return CNT_INC;
        if (ack && !issue) return CNT_DEC;
        return CNT_HOLD;
    endfunction
endpackage

// File: rtl/fence_entry.sv
module fence_entry
    import fence_pkg::*;
#(
    parameter int unsigned TIME_W  = DEF_TIME_W,
    parameter int unsigned OUTST_W = DEF_OUTST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] global_time,
    input  logic              issue_hit,
    input  logic              ack_hit,
    input  logic [TIME_W-1:0] ack_gwct,
    input  logic              fence_hit,
    input  logic              grant,
    output logic              eligible,
    output logic              blocked
);
    typedef struct packed {
        logic [TIME_W-1:0]  gwct;
        logic [OUTST_W-1:0] outst;
        logic               fenced;
    } ent_t;

    ent_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (cnt_op(issue_hit, ack_hit))
            CNT_INC: st_d.outst = st_q.outst + OUTST_W'(1);
            CNT_DEC: st_d.outst = st_q.outst - OUTST_W'(1);
            default: st_d.outst = st_q.outst;
        endcase
        if (grant) begin
            st_d.gwct = '0;
        end else if (ack_hit && (ack_gwct > st_q.gwct)) begin
            st_d.gwct = ack_gwct;
        end
        st_d.fenced = (st_q.fenced && !grant) || fence_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eligible = st_q.fenced && (st_q.outst == '0) && (global_time > st_q.gwct);
    assign blocked  = st_q.fenced;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_hit && !ack_hit) |-> (st_q.outst != '1)); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !issue_hit) |-> (st_q.outst != '0)); // R10
    AST_GWCT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |=> (st_q.gwct >= $past(st_q.gwct))); // R3
    AST_GRANT_UNBLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !fence_hit) |=> !blocked); // R2
endmodule

// File: rtl/fence_arb.sv
module fence_arb #(
    parameter int unsigned NUM_WARPS = 8,
    parameter int unsigned WID_W     = $clog2(NUM_WARPS)
) (
    input  logic [NUM_WARPS-1:0] req,
    output logic [NUM_WARPS-1:0] grant,
    output logic                 any,
    output logic [WID_W-1:0]     idx
);
    always_comb begin
        idx   = '0;
        grant = '0;
        any   = |req;
        for (int i = NUM_WARPS - 1; i >= 0; i--) begin
            if (req[i]) idx = WID_W'(i);
        end
        if (any) grant[idx] = 1'b1;
    end
endmodule

// File: rtl/fence_tracker.sv
module fence_tracker
    import fence_pkg::*;
#(
    parameter int unsigned NUM_WARPS = DEF_WARPS,
    parameter int unsigned TIME_W    = DEF_TIME_W,
    parameter int unsigned OUTST_W   = DEF_OUTST_W,
    localparam int unsigned WID_W    = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_issue_vld,
    input  logic [WID_W-1:0]     st_issue_warp,
    input  logic                 st_ack_vld,
    input  logic [WID_W-1:0]     st_ack_warp,
    input  logic [TIME_W-1:0]    st_ack_gwct,
    input  logic                 fence_vld,
    input  logic [WID_W-1:0]     fence_warp,
    input  logic [TIME_W-1:0]    global_time,
    output logic [NUM_WARPS-1:0] fence_blocked_o,
    output logic                 rel_vld_o,
    output logic [WID_W-1:0]     rel_warp_o
);
    typedef struct packed {
        logic             vld;
        logic [WID_W-1:0] warp;
    } rel_t;

    logic [NUM_WARPS-1:0] elig;
    logic [NUM_WARPS-1:0] grant;
    logic                 grant_any;
    logic [WID_W-1:0]     grant_idx;
    rel_t                 rel_d, rel_q;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_ent
        fence_entry #(
            .TIME_W  (TIME_W),
            .OUTST_W (OUTST_W)
        ) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .global_time (global_time),
            .issue_hit   (st_issue_vld && (st_issue_warp == WID_W'(w))),
            .ack_hit     (st_ack_vld && (st_ack_warp == WID_W'(w))),
            .ack_gwct    (st_ack_gwct),
            .fence_hit   (fence_vld && (fence_warp == WID_W'(w))),
            .grant       (grant[w]),
            .eligible    (elig[w]),
            .blocked     (fence_blocked_o[w])
        );
    end

    fence_arb #(
        .NUM_WARPS (NUM_WARPS),
        .WID_W     (WID_W)
    ) u_arb (
        .req   (elig),
        .grant (grant),
        .any   (grant_any),
        .idx   (grant_idx)
    );

    always_comb begin
        rel_d      = rel_q;
        rel_d.vld  = grant_any;
        rel_d.warp = grant_any ? grant_idx : rel_q.warp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_q <= '0;
        end else begin
            rel_q <= rel_d;
        end
    end

    assign rel_vld_o  = rel_q.vld;
    assign rel_warp_o = rel_q.warp;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R7
    AST_PULSE_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any |=> rel_vld_o); // R2
endmodule

// File: tb/sim_fence_tracker.sv
`timescale 1ns/1ps
module sim_fence_tracker;
    localparam int unsigned NW = 8;
    localparam int unsigned TW = 16;
    localparam int NV = 38;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          st_issue_vld;
    logic [2:0]    st_issue_warp;
    logic          st_ack_vld;
    logic [2:0]    st_ack_warp;
    logic [TW-1:0] st_ack_gwct;
    logic          fence_vld;
    logic [2:0]    fence_warp;
    logic [TW-1:0] global_time;
    logic [NW-1:0] fence_blocked_o;
    logic          rel_vld_o;
    logic [2:0]    rel_warp_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fence_tracker u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .st_issue_vld    (st_issue_vld),
        .st_issue_warp   (st_issue_warp),
        .st_ack_vld      (st_ack_vld),
        .st_ack_warp     (st_ack_warp),
        .st_ack_gwct     (st_ack_gwct),
        .fence_vld       (fence_vld),
        .fence_warp      (fence_warp),
        .global_time     (global_time),
        .fence_blocked_o (fence_blocked_o),
        .rel_vld_o       (rel_vld_o),
        .rel_warp_o      (rel_warp_o)
    );

    // Vector layout: [43:40] req, [39] issue, [38:36] issue warp, [35] ack,
    // [34:32] ack warp, [31:24] ack time, [23] fence, [22:20] fence warp,
    // [19:12] global time, [11:4] expected blocked, [3] expected pulse,
    // [2:0] expected released warp.
    function automatic logic [43:0] vec(int rq, int iv, int iw, int av, int aw, int ag,
                                        int fv, int fw, int gt, int eb, int er, int ew);
        return {4'(rq), 1'(iv), 3'(iw), 1'(av), 3'(aw), 8'(ag),
                1'(fv), 3'(fw), 8'(gt), 8'(eb), 1'(er), 3'(ew)};
    endfunction

    localparam logic [43:0] VECS [NV] = '{
        vec(2, 0,0, 0,0,0,  1,0, 5,  8'h01, 0,0), // R2 fence w0
        vec(2, 0,0, 0,0,0,  0,0, 6,  8'h00, 1,0), // R2 release w0
        vec(2, 0,0, 0,0,0,  0,0, 7,  8'h00, 0,0), // R2 single pulse
        vec(4, 1,2, 0,0,0,  0,0, 7,  8'h00, 0,0), // R4 issue w2
        vec(4, 0,0, 0,0,0,  1,2, 8,  8'h04, 0,0), // R4 fence w2
        vec(4, 0,0, 0,0,0,  0,0, 9,  8'h04, 0,0), // R4 held by count
        vec(4, 0,0, 1,2,12, 0,0, 10, 8'h04, 0,0), // R4 ack w2
        vec(3, 0,0, 0,0,0,  0,0, 12, 8'h04, 0,0), // R3 equal time holds
        vec(3, 0,0, 0,0,0,  0,0, 13, 8'h00, 1,2), // R3 release w2
        vec(6, 1,5, 0,0,0,  0,0, 13, 8'h00, 0,0), // R6 issue w5
        vec(6, 0,0, 1,5,20, 1,5, 14, 8'h20, 0,0), // R6 ack+fence w5
        vec(6, 0,0, 0,0,0,  0,0, 20, 8'h20, 0,0), // R6 ack time counted
        vec(6, 0,0, 0,0,0,  0,0, 21, 8'h00, 1,5), // R6 release w5
        vec(7, 1,1, 0,0,0,  0,0, 22, 8'h00, 0,0), // R7 issue w1
        vec(7, 1,3, 0,0,0,  0,0, 22, 8'h00, 0,0), // R7 issue w3
        vec(7, 0,0, 1,3,30, 0,0, 23, 8'h00, 0,0), // R7 ack w3
        vec(7, 0,0, 1,1,30, 0,0, 23, 8'h00, 0,0), // R7 ack w1
        vec(7, 0,0, 0,0,0,  1,3, 24, 8'h08, 0,0), // R7 fence w3
        vec(7, 0,0, 0,0,0,  1,1, 25, 8'h0A, 0,0), // R7 fence w1
        vec(7, 0,0, 0,0,0,  0,0, 30, 8'h0A, 0,0), // R7 both held
        vec(7, 0,0, 0,0,0,  0,0, 31, 8'h08, 1,1), // R7 lowest first
        vec(7, 0,0, 0,0,0,  0,0, 31, 8'h00, 1,3), // R7 then w3
        vec(7, 0,0, 0,0,0,  0,0, 31, 8'h00, 0,0), // R7 idle
        vec(8, 1,4, 0,0,0,  0,0, 32, 8'h00, 0,0), // R8 issue w4
        vec(8, 0,0, 0,0,0,  1,6, 32, 8'h40, 0,0), // R8 fence w6
        vec(8, 0,0, 1,4,90, 0,0, 33, 8'h00, 1,6), // R8 w4 ack, w6 free
        vec(9, 0,0, 0,0,0,  1,4, 34, 8'h10, 0,0), // R9 fence w4
        vec(9, 0,0, 0,0,0,  1,4, 35, 8'h10, 0,0), // R9 second fence
        vec(9, 0,0, 0,0,0,  0,0, 91, 8'h00, 1,4), // R9 release w4
        vec(9, 0,0, 0,0,0,  0,0, 92, 8'h00, 0,0), // R9 no extra pulse
        vec(5, 0,0, 0,0,0,  1,4, 1,  8'h10, 0,0), // R5 fence w4 low time
        vec(5, 0,0, 0,0,0,  0,0, 1,  8'h00, 1,4), // R5 entry was cleared
        vec(4, 1,7, 0,0,0,  0,0, 2,  8'h00, 0,0), // R4 issue w7
        vec(4, 1,7, 1,7,3,  0,0, 2,  8'h00, 0,0), // R4 issue+ack net zero
        vec(4, 0,0, 0,0,0,  1,7, 10, 8'h80, 0,0), // R4 fence w7
        vec(4, 0,0, 0,0,0,  0,0, 11, 8'h80, 0,0), // R4 one still pending
        vec(4, 0,0, 1,7,4,  0,0, 11, 8'h80, 0,0), // R4 last ack
        vec(4, 0,0, 0,0,0,  0,0, 11, 8'h00, 1,7)  // R4 release w7
    };

    task automatic drive_idle();
        st_issue_vld  = 1'b0; st_issue_warp = '0;
        st_ack_vld    = 1'b0; st_ack_warp   = '0; st_ack_gwct = '0;
        fence_vld     = 1'b0; fence_warp    = '0;
    endtask

    task automatic check(int rq, logic [7:0] eb, logic er, logic [2:0] ew);
        n_chk++;
        if (fence_blocked_o !== eb || rel_vld_o !== er || (er && rel_warp_o !== ew)) begin
            n_fail++;
            $display("FAIL R%0d: blocked=%h pulse=%b warp=%0d expected blocked=%h pulse=%b warp=%0d",
                     rq, fence_blocked_o, rel_vld_o, rel_warp_o, eb, er, ew);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        global_time = '0;
        drive_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, 8'h00, 1'b0, 3'd0); // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 8'h00, 1'b0, 3'd0); // R1 first cycle after reset
        for (int k = 0; k < NV; k++) begin
            logic [43:0] v;
            v = VECS[k];
            st_issue_vld  = v[39]; st_issue_warp = v[38:36];
            st_ack_vld    = v[35]; st_ack_warp   = v[34:32];
            st_ack_gwct   = TW'(v[31:24]);
            fence_vld     = v[23]; fence_warp    = v[22:20];
            global_time   = TW'(v[19:12]);
            @(negedge clk);
            check(int'(v[43:40]), v[11:4], v[3], v[2:0]);
        end
        // R1: a blocked warp is cleared by reset and never pulses afterwards
        drive_idle();
        fence_vld = 1'b1; fence_warp = 3'd2; global_time = 16'd40;
        @(negedge clk);
        check(1, 8'h04, 1'b0, 3'd0); // R1 setup
        drive_idle();
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 8'h00, 1'b0, 3'd0); // R1 reset clears flag
        rst_n = 1'b1;
        global_time = 16'd50;
        @(negedge clk);
        check(1, 8'h00, 1'b0, 3'd0); // R1 no pulse after reset
        @(negedge clk);
        check(1, 8'h00, 1'b0, 3'd0); // R1 still idle
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end
endmodule